// File: doc/BRIEF.md
# Coherent Snooping Write-Back Cache

This block is a small direct-mapped write-back data cache that sits between one processor and a shared snooping bus. Each line carries one data word, an address tag and a two-bit coherence state (Invalid, Shared, Exclusive, Modified). The block uses an invalidate protocol, so copies held by other caches stay consistent with this one. The processor holds a request (read or write, address, write data) until `cpu_ready` pulses for one cycle. Read data is valid in that cycle.

On the bus side, the block raises `bus_req` and keeps it high until `bus_gnt`. In a granted cycle it drives one command: read, read-with-intent-to-modify, invalidate or write-back. The other agents answer in that same cycle with `bus_rdata`, the wired-OR `bus_shared` line and `bus_retry`. The cache also watches the other masters' commands on the `snp_*` inputs. It answers a snooped read by supplying its data. When its copy is dirty, it flags the copy-back that memory must capture. It blocks a read-with-intent-to-modify aimed at a Modified line by asserting retry, then takes the bus and writes that line back. The control machine has five states:

- IDLE: serves hits.
- EVICT: writes back a dirty victim.
- FILL: issues the read or read-with-intent-to-modify, and re-issues it on retry.
- UPGRADE: broadcasts an invalidate for a write hit to a Shared line.
- DONE: the one-cycle ready pulse after a bus sequence.

The transitions are:

- IDLE→UPGRADE on a write hit in Shared.
- IDLE→EVICT on a miss whose victim is Modified.
- IDLE→FILL on any other miss.
- EVICT→FILL after the write-back.
- UPGRADE→FILL when the line is lost while waiting.
- UPGRADE→DONE after the invalidate.
- FILL→DONE after a fill that was not retried.
- DONE→IDLE.

Top module: `snoop_cache`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready` and `bus_req` are low, and a snooped read of any address gets no `snp_shared` response.
- R2: A read hit returns the stored word in the same cycle as the request (`cpu_ready` high at once), issues no bus command and leaves the state unchanged.
- R3: A read miss issues one read command (code 0). The fill enters Exclusive if `bus_shared` is low in the granted cycle, and Shared otherwise. The data is taken from `bus_rdata`.
- R4: A write hit to a Modified or Exclusive line updates the word, completes without any bus command, and leaves the line Modified.
- R5: A write hit to a Shared line first issues an invalidate (code 2), then writes and enters Modified. If a snooped invalidate removes the line while it waits for grant, the write completes with a read-with-intent-to-modify (code 1) instead.
- R6: A write miss issues a read-with-intent-to-modify and installs the write data in Modified.
- R7: `bus_req` stays high until `bus_gnt`. A command is driven only in a granted cycle. A read-with-intent-to-modify that sees `bus_retry` is re-issued until it completes.
- R8: A snooped read (code 0) matching a valid line raises `snp_shared` with the word on `snp_data` and moves the line to Shared. `snp_copyback` is also raised when the line was Modified.
- R9: A snooped read-with-intent-to-modify matching a Modified line raises `snp_retry`. The cache then requests the bus, writes the line back (code 3) and invalidates it. A match in Exclusive or Shared moves the line to Invalid with no retry.
- R10: A snooped invalidate matching a Shared line makes it Invalid. A snooped command whose tag differs from the stored tag has no effect.
- R11: A miss whose victim is Modified first writes the victim back (address rebuilt from its tag and index), then fills. A victim in Exclusive or Shared is dropped with no bus command.
- R12: In a cycle with `snp_valid` high, the cache does not start or answer a local request. The request is served in a later cycle.
- R13: `cpu_ready` stays low while a bus sequence is in progress. A miss with a clean victim completes after two cycles, and one with a dirty victim after three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; low IDX_W bits index the line |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_valid | output | 1 | Command driven this cycle |
| bus_cmd | output | 2 | 0 read, 1 read-with-intent-to-modify, 2 invalidate, 3 write-back |
| bus_addr | output | ADDR_W | Command address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_rdata | input | DATA_W | Fill data from memory or a peer cache |
| bus_shared | input | 1 | Wired-OR shared response |
| bus_retry | input | 1 | Retry response from a peer |
| snp_valid | input | 1 | Another master's command is on the bus |
| snp_cmd | input | 2 | Snooped command code |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds the line and supplies it |
| snp_copyback | output | 1 | Supplied data is dirty; memory must capture it |
| snp_retry | output | 1 | Blocks the snooped command |
| snp_data | output | DATA_W | Supplied word |

## Verification
Embedded properties check the bus handshake on every cycle: a request is held until grant, a command appears only when granted, and a retried read-with-intent-to-modify is followed by a re-request. They also check that a snoop response is never both a retry and a supply, and that a pending snoop write-back persists until issued. They confirm that a snoop update and a local update never hit the same line in one cycle, and that ready stays low while a bus sequence is active. The resulting states can only be shown by the bench's scenarios: Exclusive versus Shared fills, silent upgrades, eviction ordering, the retry-then-reissue exchange, and the fall-back from invalidate to a full read-with-intent-to-modify. The bench exposes each state through later accesses and snoop responses.

// File: rtl/snoop_cache_pkg.sv
package snoop_cache_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        CMD_RD    = 2'd0,
        CMD_RWITM = 2'd1,
        CMD_INV   = 2'd2,
        CMD_WB    = 2'd3
    } bus_cmd_t;
endpackage

// File: rtl/sc_lines.sv
module sc_lines
    import snoop_cache_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  a_idx,
    output line_st_t          a_state,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output line_st_t          b_state,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic              w_en,
    input  logic [IDX_W-1:0]  w_idx,
    input  logic [TAG_W-1:0]  w_tag,
    input  line_st_t          w_state,
    input  logic [DATA_W-1:0] w_data,
    input  logic              s_en,
    input  logic [IDX_W-1:0]  s_idx,
    input  line_st_t          s_state
);
    timeunit 1ns;
    timeprecision 1ps;

    line_st_t          st_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[g]   <= ST_I;
                tag_q[g]  <= '0;
                data_q[g] <= '0;
            end else if (s_en && s_idx == IDX_W'(g)) begin
                st_q[g] <= s_state;
            end else if (w_en && w_idx == IDX_W'(g)) begin
                st_q[g]   <= w_state;
                tag_q[g]  <= w_tag;
                data_q[g] <= w_data;
            end
        end
    end

    assign a_state = st_q[a_idx];
    assign a_tag   = tag_q[a_idx];
    assign a_data  = data_q[a_idx];
    assign b_state = st_q[b_idx];
    assign b_tag   = tag_q[b_idx];
    assign b_data  = data_q[b_idx];

    // R12: snoop-side and local-side updates never land on one line together
    p_no_clash_r12: assert property (@(posedge clk) disable iff (rst)
        !(w_en && s_en && w_idx == s_idx));
endmodule

// File: rtl/sc_snoop.sv
module sc_snoop
    import snoop_cache_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 8,
    parameter int ADDR_W = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  line_st_t          l_state,
    input  logic [TAG_W-1:0]  l_tag,
    input  logic [DATA_W-1:0] l_data,
    output logic              snp_shared,
    output logic              snp_copyback,
    output logic              snp_retry,
    output logic [DATA_W-1:0] snp_data,
    output logic              s_en,
    output logic [IDX_W-1:0]  s_idx,
    output line_st_t          s_state,
    input  logic              wb_done,
    output logic              wb_pend,
    output logic [IDX_W-1:0]  wb_idx
);
    timeunit 1ns;
    timeprecision 1ps;

    bus_cmd_t cmd;
    logic     match;

    assign cmd      = bus_cmd_t'(snp_cmd);
    assign s_idx    = snp_addr[IDX_W-1:0];
    assign match    = snp_valid && l_state != ST_I && l_tag == snp_addr[ADDR_W-1:IDX_W];
    assign snp_data = l_data;

    always_comb begin
        snp_shared   = 1'b0;
        snp_copyback = 1'b0;
        snp_retry    = 1'b0;
        s_en         = 1'b0;
        s_state      = l_state;
        if (match) begin
            unique case (cmd)
                CMD_RD: begin
                    snp_shared   = 1'b1;
                    snp_copyback = (l_state == ST_M);
                    s_en         = 1'b1;
                    s_state      = ST_S;
                end
                CMD_RWITM: begin
                    if (l_state == ST_M) begin
                        snp_retry = 1'b1;
                    end else begin
                        s_en    = 1'b1;
                        s_state = ST_I;
                    end
                end
                CMD_INV: begin
                    if (l_state == ST_S) begin
                        s_en    = 1'b1;
                        s_state = ST_I;
                    end
                end
                CMD_WB: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_pend <= 1'b0;
            wb_idx  <= '0;
        end else if (snp_retry) begin
            wb_pend <= 1'b1;
            wb_idx  <= s_idx;
        end else if (wb_done) begin
            wb_pend <= 1'b0;
        end
    end

    // R8: a snoop answer never both supplies and blocks
    p_one_answer_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({snp_retry, snp_shared}));
    // R9: an owed write-back stays owed until it is issued
    p_pend_kept_r9: assert property (@(posedge clk) disable iff (rst)
        wb_pend && !wb_done && !snp_retry |=> wb_pend);
endmodule

// File: rtl/sc_ctrl.sv
module sc_ctrl
    import snoop_cache_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 8,
    parameter int ADDR_W = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic [IDX_W-1:0]  a_idx,
    input  line_st_t          a_state,
    input  logic [TAG_W-1:0]  a_tag,
    input  logic [DATA_W-1:0] a_data,
    output logic              w_en,
    output logic [IDX_W-1:0]  w_idx,
    output logic [TAG_W-1:0]  w_tag,
    output line_st_t          w_state,
    output logic [DATA_W-1:0] w_data,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_valid,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_shared,
    input  logic              bus_retry,
    input  logic              snp_valid,
    input  logic              wb_pend,
    input  logic [IDX_W-1:0]  wb_idx,
    output logic              wb_done
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [2:0] {F_IDLE, F_EVICT, F_FILL, F_UPG, F_DONE} fsm_t;

    fsm_t             state_q, state_d;
    bus_cmd_t         cmd_d;
    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    logic             hit, wb_slot;

    assign idx       = cpu_addr[IDX_W-1:0];
    assign tag       = cpu_addr[ADDR_W-1:IDX_W];
    assign wb_slot   = wb_pend && bus_gnt;
    assign a_idx     = wb_slot ? wb_idx : idx;
    assign hit       = a_state != ST_I && a_tag == tag;
    assign bus_req   = wb_pend || state_q == F_EVICT || state_q == F_FILL || state_q == F_UPG;
    assign bus_cmd   = cmd_d;
    assign cpu_rdata = a_data;

    always_ff @(posedge clk) begin
        if (rst) state_q <= F_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        w_en      = 1'b0;
        w_idx     = idx;
        w_tag     = tag;
        w_state   = a_state;
        w_data    = a_data;
        bus_valid = 1'b0;
        cmd_d     = CMD_RD;
        bus_addr  = cpu_addr;
        bus_wdata = a_data;
        wb_done   = 1'b0;
        cpu_ready = 1'b0;
        if (wb_slot) begin
            bus_valid = 1'b1;
            cmd_d     = CMD_WB;
            bus_addr  = {a_tag, wb_idx};
            w_en      = 1'b1;
            w_idx     = wb_idx;
            w_tag     = a_tag;
            w_state   = ST_I;
            wb_done   = 1'b1;
        end else begin
            unique case (state_q)
                F_IDLE: begin
                    if (cpu_req && !snp_valid) begin
                        if (hit && !cpu_we) begin
                            cpu_ready = 1'b1;
                        end else if (hit && a_state != ST_S) begin
                            w_en      = 1'b1;
                            w_state   = ST_M;
                            w_data    = cpu_wdata;
                            cpu_ready = 1'b1;
                        end else if (hit) begin
                            state_d = F_UPG;
                        end else begin
                            state_d = (a_state == ST_M) ? F_EVICT : F_FILL;
                        end
                    end
                end
                F_EVICT: begin
                    if (bus_gnt) begin
                        bus_valid = 1'b1;
                        cmd_d     = CMD_WB;
                        bus_addr  = {a_tag, idx};
                        w_en      = 1'b1;
                        w_tag     = a_tag;
                        w_state   = ST_I;
                        state_d   = F_FILL;
                    end
                end
                F_FILL: begin
                    if (bus_gnt) begin
                        bus_valid = 1'b1;
                        cmd_d     = cpu_we ? CMD_RWITM : CMD_RD;
                        if (!bus_retry) begin
                            w_en    = 1'b1;
                            w_state = cpu_we ? ST_M : (bus_shared ? ST_S : ST_E);
                            w_data  = cpu_we ? cpu_wdata : bus_rdata;
                            state_d = F_DONE;
                        end
                    end
                end
                F_UPG: begin
                    if (!(hit && a_state == ST_S)) begin
                        state_d = F_FILL;
                    end else if (bus_gnt) begin
                        bus_valid = 1'b1;
                        cmd_d     = CMD_INV;
                        w_en      = 1'b1;
                        w_state   = ST_M;
                        w_data    = cpu_wdata;
                        state_d   = F_DONE;
                    end
                end
                F_DONE: begin
                    cpu_ready = 1'b1;
                    state_d   = F_IDLE;
                end
            endcase
        end
    end

    // R7: request held until granted, commands only when granted, retry re-requests
    p_req_held_r7: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_gnt |=> bus_req);
    p_cmd_granted_r7: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> bus_gnt);
    p_retry_reissue_r7: assert property (@(posedge clk) disable iff (rst)
        bus_valid && bus_retry && bus_cmd == CMD_RWITM |=> bus_req);
    // R13: no completion pulse while a bus sequence is active
    p_busy_quiet_r13: assert property (@(posedge clk) disable iff (rst)
        (state_q == F_EVICT || state_q == F_FILL || state_q == F_UPG) |-> !cpu_ready);
endmodule

// File: rtl/snoop_cache.sv
module snoop_cache
    import snoop_cache_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int LINES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_valid,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_shared,
    input  logic              bus_retry,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_copyback,
    output logic              snp_retry,
    output logic [DATA_W-1:0] snp_data
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  a_idx, w_idx, s_idx, wb_idx;
    line_st_t          a_state, b_state, w_state, s_state;
    logic [TAG_W-1:0]  a_tag, b_tag, w_tag;
    logic [DATA_W-1:0] a_data, b_data, w_data;
    logic              w_en, s_en, wb_pend, wb_done;

    sc_lines #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_lines (
        .clk(clk), .rst(rst),
        .a_idx(a_idx), .a_state(a_state), .a_tag(a_tag), .a_data(a_data),
        .b_idx(s_idx), .b_state(b_state), .b_tag(b_tag), .b_data(b_data),
        .w_en(w_en), .w_idx(w_idx), .w_tag(w_tag), .w_state(w_state), .w_data(w_data),
        .s_en(s_en), .s_idx(s_idx), .s_state(s_state)
    );

    sc_snoop #(.TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_snoop (
        .clk(clk), .rst(rst),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .l_state(b_state), .l_tag(b_tag), .l_data(b_data),
        .snp_shared(snp_shared), .snp_copyback(snp_copyback), .snp_retry(snp_retry),
        .snp_data(snp_data), .s_en(s_en), .s_idx(s_idx), .s_state(s_state),
        .wb_done(wb_done), .wb_pend(wb_pend), .wb_idx(wb_idx)
    );

    sc_ctrl #(.TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .a_idx(a_idx), .a_state(a_state), .a_tag(a_tag), .a_data(a_data),
        .w_en(w_en), .w_idx(w_idx), .w_tag(w_tag), .w_state(w_state), .w_data(w_data),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_cmd(bus_cmd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_shared(bus_shared), .bus_retry(bus_retry), .snp_valid(snp_valid),
        .wb_pend(wb_pend), .wb_idx(wb_idx), .wb_done(wb_done)
    );
endmodule

// File: tb/snoop_cache_bench.sv
module snoop_cache_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [1:0] C_RD = 2'd0, C_RWITM = 2'd1, C_INV = 2'd2, C_WB = 2'd3;

    logic       clk = 1'b0, rst = 1'b1;
    logic       cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0] cpu_addr = '0, cpu_wdata = '0, cpu_rdata;
    logic       cpu_ready, bus_req, bus_gnt, bus_valid, bus_shared, bus_retry;
    logic [1:0] bus_cmd;
    logic [7:0] bus_addr, bus_wdata, bus_rdata;
    logic       snp_valid = 1'b0;
    logic [1:0] snp_cmd = '0;
    logic [7:0] snp_addr = '0, snp_data;
    logic       snp_shared, snp_copyback, snp_retry;

    logic       gnt_en = 1'b1, peer_shared = 1'b0;
    logic [7:0] peer_data = 8'hC5;
    int         retry_want = 0, retry_seen;
    logic [7:0] mem [256];
    logic [1:0] log_cmd [256];
    logic [7:0] log_addr [256], log_data [256];
    int         n_log;
    int         checks = 0, errors = 0;

    always #5 clk = ~clk;

    snoop_cache u_snoop_cache (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_cmd(bus_cmd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_shared(bus_shared), .bus_retry(bus_retry), .snp_valid(snp_valid),
        .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_shared(snp_shared),
        .snp_copyback(snp_copyback), .snp_retry(snp_retry), .snp_data(snp_data)
    );

    // arbiter, peer cache and memory model
    assign bus_gnt    = bus_req && gnt_en && !snp_valid;
    assign bus_shared = bus_valid && bus_cmd == C_RD && peer_shared;
    assign bus_retry  = bus_valid && bus_cmd == C_RWITM && retry_seen < retry_want;
    assign bus_rdata  = peer_shared ? peer_data : mem[bus_addr];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
            n_log = 0;
            retry_seen = 0;
        end else if (bus_valid) begin
            log_cmd[n_log % 256]  = bus_cmd;
            log_addr[n_log % 256] = bus_addr;
            log_data[n_log % 256] = bus_wdata;
            n_log++;
            if (bus_cmd == C_WB) mem[bus_addr] = bus_wdata;
            if (bus_retry) begin
                retry_seen++;
                mem[bus_addr] = 8'hEE;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cpu_op(input bit we, input logic [7:0] a, input logic [7:0] d,
                          output logic [7:0] rd, output int cyc);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cyc = 0;
        #1;
        while (!cpu_ready && cyc < 500) begin
            @(negedge clk); #1; cyc++;
        end
        rd = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic snoop(input logic [1:0] c, input logic [7:0] a,
                         output bit sh, output bit cb, output bit rt, output logic [7:0] dt);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
        #1;
        sh = snp_shared; cb = snp_copyback; rt = snp_retry; dt = snp_data;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd, dt, a;
        int cyc, n0;
        bit sh, cb, rt;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(!cpu_ready && !bus_req, "R1 idle outputs", {cpu_ready, bus_req}, 0);
        for (int i = 0; i < 4; i++) begin
            snoop(C_RD, 8'((i + 1) * 4 + i), sh, cb, rt, dt);
            check(!sh, "R1 line empty", sh, 0);
        end

        // sweep: read miss (alternating sharer), write hit, then two snooped reads
        for (int i = 0; i < 4; i++) begin
            a = 8'((i + 1) * 4 + i);
            peer_shared = i[0];
            n0 = n_log;
            cpu_op(1'b0, a, 8'h00, rd, cyc);
            check(rd == (i[0] ? peer_data : (a ^ 8'h5A)), "R3 fill data", rd,
                  i[0] ? peer_data : (a ^ 8'h5A));
            check(n_log == n0 + 1 && log_cmd[n0 % 256] == C_RD && log_addr[n0 % 256] == a,
                  "R3 one read", log_cmd[n0 % 256], C_RD);
            check(cyc == 2, "R13 miss latency", cyc, 2);
            peer_shared = 1'b0;
            n0 = n_log;
            cpu_op(1'b1, a, 8'(8'h30 + i), rd, cyc);
            if (i[0])
                check(n_log == n0 + 1 && log_cmd[n0 % 256] == C_INV, "R5 invalidate first",
                      n_log - n0, 1);
            else
                check(n_log == n0 && cyc == 0, "R4 silent upgrade", n_log - n0, 0);
            snoop(C_RD, a, sh, cb, rt, dt);
            check(sh && cb && dt == 8'(8'h30 + i), "R8 dirty supply", {sh, cb, dt}, {2'b11, 8'(8'h30 + i)});
            snoop(C_RD, a, sh, cb, rt, dt);
            check(sh && !cb, "R8 now shared", {sh, cb}, 2'b10);
        end

        // read hit
        n0 = n_log;
        cpu_op(1'b0, 8'h04, 8'h00, rd, cyc);
        check(rd == 8'h30 && cyc == 0 && n_log == n0, "R2 read hit", rd, 8'h30);

        // snooped invalidate: other tag ignored, matching tag removes
        snoop(C_INV, 8'h1C, sh, cb, rt, dt);
        n0 = n_log;
        cpu_op(1'b0, 8'h04, 8'h00, rd, cyc);
        check(rd == 8'h30 && n_log == n0, "R10 tag mismatch ignored", n_log - n0, 0);
        snoop(C_INV, 8'h04, sh, cb, rt, dt);
        snoop(C_RD, 8'h04, sh, cb, rt, dt);
        check(!sh, "R10 invalidated", sh, 0);

        // write miss
        n0 = n_log;
        cpu_op(1'b1, 8'h24, 8'h77, rd, cyc);
        check(n_log == n0 + 1 && log_cmd[n0 % 256] == C_RWITM && log_addr[n0 % 256] == 8'h24,
              "R6 write miss command", log_cmd[n0 % 256], C_RWITM);
        n0 = n_log;
        cpu_op(1'b0, 8'h24, 8'h00, rd, cyc);
        check(rd == 8'h77 && n_log == n0, "R6 write installed", rd, 8'h77);

        // eviction of a dirty victim, then of a clean one
        n0 = n_log;
        cpu_op(1'b0, 8'h28, 8'h00, rd, cyc);
        check(n_log == n0 + 2 && log_cmd[n0 % 256] == C_WB && log_addr[n0 % 256] == 8'h24 &&
              log_data[n0 % 256] == 8'h77 && log_cmd[(n0 + 1) % 256] == C_RD,
              "R11 write-back before fill", log_cmd[n0 % 256], C_WB);
        check(mem[8'h24] == 8'h77 && rd == (8'h28 ^ 8'h5A), "R11 memory updated", mem[8'h24], 8'h77);
        check(cyc == 3, "R13 dirty miss latency", cyc, 3);
        n0 = n_log;
        cpu_op(1'b0, 8'h2C, 8'h00, rd, cyc);
        check(n_log == n0 + 1 && log_cmd[n0 % 256] == C_RD, "R11 clean victim dropped", n_log - n0, 1);

        // retry then re-issue
        retry_want = retry_seen + 1;
        n0 = n_log;
        cpu_op(1'b1, 8'h31, 8'h99, rd, cyc);
        check(n_log == n0 + 2 && log_cmd[n0 % 256] == C_RWITM && log_cmd[(n0 + 1) % 256] == C_RWITM,
              "R7 reissue after retry", n_log - n0, 2);
        cpu_op(1'b0, 8'h31, 8'h00, rd, cyc);
        check(rd == 8'h99, "R7 write completed", rd, 8'h99);

        // snooped RWITM on Modified: retry, then write-back and invalidate
        snoop(C_RWITM, 8'h31, sh, cb, rt, dt);
        check(rt && !sh, "R9 retry on modified", rt, 1);
        n0 = n_log;
        repeat (3) @(negedge clk);
        check(n_log == n0 + 1 && log_cmd[n0 % 256] == C_WB && log_addr[n0 % 256] == 8'h31 &&
              log_data[n0 % 256] == 8'h99, "R9 write-back issued", log_cmd[n0 % 256], C_WB);
        snoop(C_RD, 8'h31, sh, cb, rt, dt);
        check(!sh, "R9 line dropped", sh, 0);
        cpu_op(1'b0, 8'h36, 8'h00, rd, cyc);
        snoop(C_RWITM, 8'h36, sh, cb, rt, dt);
        check(!rt, "R9 no retry on exclusive", rt, 0);
        snoop(C_RD, 8'h36, sh, cb, rt, dt);
        check(!sh, "R9 exclusive dropped", sh, 0);

        // snoop priority over a local hit in the same cycle
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h13;
        snp_valid = 1'b1; snp_cmd = C_RD; snp_addr = 8'h22;
        #1;
        check(!cpu_ready, "R12 local held during snoop", cpu_ready, 0);
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        check(cpu_ready && cpu_rdata == 8'h33, "R12 served after snoop", cpu_rdata, 8'h33);
        @(negedge clk);
        cpu_req = 1'b0;

        // upgrade loses its Shared copy while waiting for grant
        gnt_en = 1'b0;
        n0 = n_log;
        fork
            cpu_op(1'b1, 8'h13, 8'h55, rd, cyc);
            begin
                repeat (3) @(negedge clk);
                snoop(C_INV, 8'h13, sh, cb, rt, dt);
                gnt_en = 1'b1;
            end
        join
        check(n_log == n0 + 1 && log_cmd[n0 % 256] == C_RWITM, "R5 fallback to full fetch",
              log_cmd[n0 % 256], C_RWITM);
        check(cyc >= 4, "R13 ready held while waiting", cyc, 4);
        snoop(C_RD, 8'h13, sh, cb, rt, dt);
        check(sh && cb && dt == 8'h55, "R5 ended modified", dt, 8'h55);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule